// File: doc/BRIEF.md
# Hierarchical Carry Look-Ahead Adder

This block adds two unsigned operands of a parameterizable power-of-two width together with a one-bit carry-in. It returns a sum of the same width and a carry-out. Each bit position forms its own propagate and generate pair. A balanced binary tree of two-input combine cells merges these pairs into group signals on the way up. Group carries then flow back down the same tree, so every bit receives its incoming carry after a logic depth of about twice log2 of the width, instead of after a ripple through every lower bit.

The adding core is purely combinational. A thin wrapper registers the result once so that the core sits between flops for timing, and a synchronous active-high reset clears that result register. The operands and the carry-in are presented in one cycle, and the sum and carry-out appear on the outputs after the next rising clock edge.

Top module: `cla_adder_reg`

## Requirements
- R1: After each rising edge with reset low, {cout_o, sum_o} equals the (WIDTH+1)-bit value a_i + b_i + cin_i sampled at that edge, for every operand pair.
- R2: cout_o is bit WIDTH of that full sum. It is 1 whenever a_i and b_i both have their most significant bit set.
- R3: cin_i adds exactly one. With a_i = b_i = 0, sum_o equals cin_i and cout_o is 0.
- R4: When every bit propagates (b_i is the bitwise inverse of a_i), cin_i = 0 gives sum_o all ones with cout_o = 0, and cin_i = 1 gives sum_o = 0 with cout_o = 1.
- R5: A carry generated in bit 0 with every higher bit propagating travels the full width: a_i = 1 with b_i all ones gives sum_o = 0 and cout_o = 1.
- R6: The result is registered. A change of inputs is invisible on sum_o and cout_o until the next rising edge. A rising edge with rst high sets sum_o and cout_o to 0.
- R7: The carry into each bit position k is correct in isolation: a_i = b_i = 2^k gives sum_o = 2^(k+1) for k below WIDTH-1, and sum_o = 0 with cout_o = 1 for k = WIDTH-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the result register |
| a_i | input | WIDTH | First operand, unsigned |
| b_i | input | WIDTH | Second operand, unsigned |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Registered sum bits |
| cout_o | output | 1 | Registered carry out of the top bit |

## Verification
The bench targets the full-length carry paths. Operand pairs with every bit propagating, with and without a carry-in, would leave a wrong low or high bit if a down-tree carry were routed to the wrong child. Walking a generated carry through each single bit position catches a mistake in the odd carries formed at leaf pairs, or a swapped lower and upper group in a combine cell. That swap breaks the group generate equation only when the operands are asymmetric, so an exhaustive sweep of all operand pairs at the default width also runs. The latency and reset checks catch a result that leaks through combinationally, or a reset that fails to clear the carry-out.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Propagate/generate pair for a single bit or a group of bits.
    typedef struct packed {
        logic prop;
        logic gen;
    } pg_t;

    // Merge a lower group with the adjacent upper group.
    function automatic pg_t pg_merge(input pg_t lower, input pg_t upper);
        pg_t r;
        r.prop = lower.prop & upper.prop;
        r.gen  = upper.gen | (upper.prop & lower.gen);
        return r;
    endfunction

    // Carry leaving a group, given the carry entering it.
    function automatic logic pg_carry(input pg_t grp, input logic cin);
        return grp.gen | (grp.prop & cin);
    endfunction

    function automatic bit is_pow2(input int unsigned v);
        return (v >= 2) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/cla_bit.sv
module cla_bit
    import cla_pkg::*;
(
    input  logic a_i,
    input  logic b_i,
    input  logic carry_i,
    output pg_t  pg_o,
    output logic sum_o
);
    always_comb begin
        pg_o.prop = a_i ^ b_i;
        pg_o.gen  = a_i & b_i;
        sum_o     = pg_o.prop ^ carry_i;
    end
endmodule

// File: rtl/cla_node.sv
module cla_node
    import cla_pkg::*;
(
    input  pg_t  lower_i,
    input  pg_t  upper_i,
    input  logic carry_i,
    output pg_t  group_o,
    output logic carry_lower_o,
    output logic carry_upper_o
);
    // Up-sweep: group signals; down-sweep: split the incoming carry.
    always_comb begin
        group_o       = pg_merge(lower_i, upper_i);
        carry_lower_o = carry_i;
        carry_upper_o = pg_carry(lower_i, carry_i);
    end
endmodule

// File: rtl/cla_tree_core.sv
module cla_tree_core
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    // Heap numbering: node 1 is the root, node k has children 2k (lower
    // bits) and 2k+1 (upper bits), leaf for bit i is node WIDTH+i.
    localparam int unsigned NODES = 2 * WIDTH;

    if (!is_pow2(WIDTH)) begin : g_width_check
        $error("cla_tree_core: WIDTH must be a power of two and at least 2");
    end

    pg_t  pg_heap    [1:NODES-1];
    logic carry_heap [1:NODES-1];

    assign carry_heap[1] = cin_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_leaf
        cla_bit u_bit (
            .a_i     (a_i[i]),
            .b_i     (b_i[i]),
            .carry_i (carry_heap[WIDTH + i]),
            .pg_o    (pg_heap[WIDTH + i]),
            .sum_o   (sum_o[i])
        );
    end

    for (genvar k = 1; k < WIDTH; k++) begin : g_node
        cla_node u_node (
            .lower_i       (pg_heap[2 * k]),
            .upper_i       (pg_heap[2 * k + 1]),
            .carry_i       (carry_heap[k]),
            .group_o       (pg_heap[k]),
            .carry_lower_o (carry_heap[2 * k]),
            .carry_upper_o (carry_heap[2 * k + 1])
        );
    end

    assign cout_o = pg_carry(pg_heap[1], cin_i);
endmodule

// File: rtl/cla_adder_reg.sv
module cla_adder_reg
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    logic [WIDTH-1:0] sum_d;
    logic             cout_d;

    cla_tree_core #(.WIDTH(WIDTH)) u_core (
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (cin_i),
        .sum_o  (sum_d),
        .cout_o (cout_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_o  <= '0;
            cout_o <= 1'b0;
        end else begin
            sum_o  <= sum_d;
            cout_o <= cout_d;
        end
    end

    AST_SUM_EXACT: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> {cout_o, sum_o} ==
            ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + {{WIDTH{1'b0}}, $past(cin_i)})); // R1

    AST_TOP_GENERATE: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(a_i[WIDTH-1]) && $past(b_i[WIDTH-1])) |-> cout_o); // R2

    AST_CIN_ONLY: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(a_i) == '0 && $past(b_i) == '0)
            |-> (sum_o == {{(WIDTH-1){1'b0}}, $past(cin_i)} && !cout_o)); // R3

    AST_FULL_PROPAGATE: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && ($past(a_i) ^ $past(b_i)) == ALL_ONES)
            |-> (cout_o == $past(cin_i) && sum_o == {WIDTH{!$past(cin_i)}})); // R4

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (sum_o == '0 && !cout_o)); // R6
endmodule

// File: tb/test_cla_adder_reg.sv
module test_cla_adder_reg;
    localparam int W = 8;
    localparam int NVEC = 13;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cla_adder_reg #(.WIDTH(W)) i_cla_adder_reg (
        .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin),
        .sum_o(sum), .cout_o(cout)
    );

    // {a, b, cin, expected 9-bit result}
    localparam logic [25:0] VEC [NVEC] = '{
        {8'h00, 8'h00, 1'b0, 9'h000},   // R3
        {8'h00, 8'h00, 1'b1, 9'h001},   // R3
        {8'hFF, 8'h00, 1'b1, 9'h100},   // R4
        {8'h55, 8'hAA, 1'b0, 9'h0FF},   // R4
        {8'h55, 8'hAA, 1'b1, 9'h100},   // R4
        {8'h01, 8'hFF, 1'b0, 9'h100},   // R5
        {8'h80, 8'h80, 1'b0, 9'h100},   // R2
        {8'hFF, 8'hFF, 1'b1, 9'h1FF},   // R2
        {8'h01, 8'h01, 1'b0, 9'h002},   // R7
        {8'h0F, 8'h01, 1'b0, 9'h010},   // R1
        {8'h7F, 8'h01, 1'b0, 9'h080},   // R1
        {8'hC3, 8'h3C, 1'b1, 9'h100},   // R4
        {8'h12, 8'h34, 1'b0, 9'h046}    // R1
    };

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive on a falling edge, result registered at the next rising edge,
    // sampled at the falling edge after that.
    task automatic apply(input logic [W-1:0] ai, input logic [W-1:0] bi, input logic ci);
        @(negedge clk);
        a = ai; b = bi; cin = ci;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #2000000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R6 reset state", {cout, sum}, '0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][25:18], VEC[i][17:10], VEC[i][9]);
            check("R1 vector table", {cout, sum}, VEC[i][8:0]);
        end

        // Carry into each single bit position
        for (int k = 0; k < W; k++) begin
            apply(W'(1) << k, W'(1) << k, 1'b0);
            check("R7 bit walk", {cout, sum}, (W+1)'(2) << k);
        end

        // Latency: new inputs invisible until the next rising edge
        apply(8'h10, 8'h20, 1'b0);
        @(negedge clk);
        a = 8'hF0; b = 8'h0F; cin = 1'b1;
        #2;
        check("R6 held before edge", {cout, sum}, 9'h030);
        @(negedge clk);
        check("R6 updated after edge", {cout, sum}, 9'h100);

        // Synchronous reset clears a nonzero result
        apply(8'hFF, 8'hFF, 1'b1);
        check("R2 before reset", {cout, sum}, 9'h1FF);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R6 reset clears", {cout, sum}, '0);
        rst = 1'b0;

        // Exhaustive sweep at the default width
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                logic ci;
                ci = logic'((x ^ y ^ (y >> 3)) & 1);
                apply(W'(x), W'(y), ci);
                check("R1 exhaustive", {cout, sum}, (W+1)'(x + y + int'(ci)));
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule